// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block watches the command lines of a four-bank synchronous DRAM and reports protocol and spacing violations. It drives nothing onto the memory bus. On each rising clock edge where clock-enable is high, it decodes the chip-select, row-strobe, column-strobe and write-enable lines into one command. It keeps, for every bank, whether a row is open, how many cycles have passed since that bank's last activate and last precharge, and whether an auto-precharge burst still holds the bank.

Each command is checked against the current state. The first rule it breaks, in the fixed priority below, is reported for one cycle as a code together with the bank concerned. A command that breaks only a spacing rule still takes effect. A command aimed at a bank in the wrong state (closed, already open, or locked) changes nothing. The per-bank open flags are brought out so that a system bench can follow the memory state.

All timing limits are parameters counted in clock cycles: activate-to-column, precharge-to-activate, activate-to-activate, activate-to-precharge, and the mode-register blackout.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as: 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. With `cs_n` high, the other command inputs are ignored, nothing is reported and no state changes.
- R2: While `cke` is low, no command is decoded, no error is reported, and all bank state, timers and the blackout count hold their values.
- R3: An activate to a closed bank sets `bank_open[ba]` after that edge. A precharge with `ap_flag` low closes only bank `ba`. A precharge with `ap_flag` high closes every open bank that is not under auto-precharge.
- R4: A violation is reported on the cycle after the offending edge: `err_valid` high for one cycle, plus `err_code` and `err_bank`. `err_code` is 0 whenever `err_valid` is low. If several rules fail, the lowest code wins. Commands on closed, open or locked banks that are flagged with codes 4, 5 or 6 have no effect. Commands flagged only for spacing still take effect.
- R5: Code 1: any command other than no-op or deselect, including burst stop, in the `T_MRD` sampled cycles after a mode set. The bank reported is `ba`. With the default `T_MRD`=2, a command on the third cycle after the mode set is legal.
- R6: A mode set with any bank open gives code 2. A refresh with any bank open gives code 3. The bank reported is the lowest-numbered open bank.
- R7: A read or write to a closed bank gives code 5. An activate to an open bank gives code 6.
- R8: A read or write with `ap_flag` high to an open bank locks that bank for BL cycles. Any read, write or activate to the bank during the lock gives code 4. The bank closes on the last cycle of the lock, and that cycle counts as its precharge for the code 8 check.
- R9: The burst length BL is latched at each mode set from `mr_bl_code`. Codes 0, 1, 2 and 3 give 1, 2, 4 and 8. Codes 4 to 7 give 8. BL is 1 after reset.
- R10: A read or write fewer than `T_RCD` cycles after its bank's activate gives code 7. An activate fewer than `T_RP` cycles after its bank's precharge gives code 8.
- R11: An activate fewer than `T_RRD` cycles after any activate gives code 9. A precharge that closes a bank fewer than `T_RAS` cycles after that bank's activate gives code 10. The bank reported is the lowest such bank.
- R12: Reads and writes on consecutive cycles, and a burst stop at any point, are legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the monitor |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| ap_flag | input | 1 | Address line 10: all-bank precharge / auto-precharge |
| mr_bl_code | input | 3 | Address lines 2..0: burst-length field at mode set |
| err_valid | output | 1 | One-cycle violation strobe |
| err_code | output | 4 | Violation code, 0 when none |
| err_bank | output | 2 | Bank the violation concerns |
| bank_open | output | 4 | Open flag per bank |

## Verification
The checks are driven by directed command sequences, each laid out so that exactly one rule sits at its boundary.

Legal sequences (back-to-back columns, burst stop, single-bank and all-bank precharge) show that the monitor stays silent when it should and closes banks correctly. Paired sequences place a command one cycle inside and one cycle outside a limit (the blackout, auto-precharge end plus tRP), which separates off-by-one errors in the timers. Burst lengths of 1 and 4 under auto-precharge show that the latched mode field, not a constant, sets the lock. Deselect and clock-enable-low stimuli show that ignored commands change neither the flags nor the strobe.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_BST
  } cmd_t;

  typedef enum logic [3:0] {
    E_NONE      = 4'd0,
    E_MRS_WIN   = 4'd1,
    E_MRS_OPEN  = 4'd2,
    E_REF_OPEN  = 4'd3,
    E_AP_LOCK   = 4'd4,
    E_RW_CLOSED = 4'd5,
    E_ACT_OPEN  = 4'd6,
    E_TRCD      = 4'd7,
    E_TRP       = 4'd8,
    E_TRRD      = 4'd9,
    E_TRAS      = 4'd10
  } err_t;

  // burst length from the mode field (R9)
  function automatic logic [3:0] bl_decode(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_t cmd,
  output logic fire
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        3'b010:  cmd = CMD_PRE;
        3'b011:  cmd = CMD_ACT;
        3'b100:  cmd = CMD_WR;
        3'b101:  cmd = CMD_RD;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
    fire = cke && (cmd != CMD_NOP);
  end
endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act,
  input  logic             pre,
  input  logic             ap_start,
  input  logic [3:0]       ap_len,
  output logic             is_open,
  output logic             locked,
  output logic [CNT_W-1:0] t_act,
  output logic [CNT_W-1:0] t_pre
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [3:0] ap_cnt;

  assign locked = (ap_cnt != 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      ap_cnt  <= 4'd0;
      t_act   <= SAT;
      t_pre   <= SAT;
    end else if (en) begin
      t_act <= act ? ONE : ((t_act == SAT) ? SAT : t_act + ONE);
      t_pre <= (t_pre == SAT) ? SAT : t_pre + ONE;
      if (act) is_open <= 1'b1;
      if (locked) begin
        ap_cnt <= ap_cnt - 4'd1;
        if (ap_cnt == 4'd1) begin
          is_open <= 1'b0;
          t_pre   <= ONE;
        end
      end else if (ap_start) begin
        ap_cnt <= ap_len;
      end else if (pre) begin
        is_open <= 1'b0;
        t_pre   <= ONE;
      end
    end
  end
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int CNT_W = 3,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RRD = 2,
  parameter int T_RAS = 5
) (
  input  cmd_t                     cmd,
  input  logic                     fire,
  input  logic [BA_W-1:0]          ba,
  input  logic                     ap_flag,
  input  logic                     mrs_win,
  input  logic [NB-1:0]            open_v,
  input  logic [NB-1:0]            lock_v,
  input  logic [NB-1:0][CNT_W-1:0] t_act,
  input  logic [NB-1:0][CNT_W-1:0] t_pre,
  input  logic [CNT_W-1:0]         t_any_act,
  output err_t                     code,
  output logic [BA_W-1:0]          bank
);
  localparam logic [CNT_W-1:0] LIM_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] LIM_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] LIM_RRD = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] LIM_RAS = CNT_W'(T_RAS);

  function automatic logic [BA_W-1:0] lowest(input logic [NB-1:0] v);
    logic [BA_W-1:0] idx;
    idx = '0;
    for (int i = NB - 1; i >= 0; i--) if (v[i]) idx = BA_W'(i);
    return idx;
  endfunction

  logic [NB-1:0] tras_hit;

  always_comb begin
    for (int i = 0; i < NB; i++)
      tras_hit[i] = open_v[i] && !lock_v[i] && (t_act[i] < LIM_RAS) &&
                    (ap_flag || (ba == BA_W'(i)));
    code = E_NONE;
    bank = ba;
    if (fire) begin
      if (mrs_win) code = E_MRS_WIN;
      else begin
        case (cmd)
          CMD_MRS: if (|open_v) begin code = E_MRS_OPEN; bank = lowest(open_v); end
          CMD_REF: if (|open_v) begin code = E_REF_OPEN; bank = lowest(open_v); end
          CMD_RD, CMD_WR: begin
            if (lock_v[ba])              code = E_AP_LOCK;
            else if (!open_v[ba])        code = E_RW_CLOSED;
            else if (t_act[ba] < LIM_RCD) code = E_TRCD;
          end
          CMD_ACT: begin
            if (lock_v[ba])               code = E_AP_LOCK;
            else if (open_v[ba])          code = E_ACT_OPEN;
            else if (t_pre[ba] < LIM_RP)  code = E_TRP;
            else if (t_any_act < LIM_RRD) code = E_TRRD;
          end
          CMD_PRE: if (|tras_hit) begin code = E_TRAS; bank = lowest(tras_hit); end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_MRD     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cke,
  input  logic                         cs_n,
  input  logic                         ras_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] ba,
  input  logic                         ap_flag,
  input  logic [2:0]                   mr_bl_code,
  output logic                         err_valid,
  output logic [3:0]                   err_code,
  output logic [$clog2(NUM_BANKS)-1:0] err_bank,
  output logic [NUM_BANKS-1:0]         bank_open
);
  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int T_M1  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_M2  = (T_RRD > T_RAS) ? T_RRD : T_RAS;
  localparam int TMAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int MRD_W = $clog2(T_MRD + 1);
  localparam logic [CNT_W-1:0] SAT = '1;

  cmd_t                           cmd;
  logic                           fire;
  logic [MRD_W-1:0]               mrs_cnt;
  logic [3:0]                     bl_q;
  logic [CNT_W-1:0]               t_any_act;
  logic [NUM_BANKS-1:0]           lock_v;
  logic [NUM_BANKS-1:0][CNT_W-1:0] t_act, t_pre;
  err_t                           code;
  logic [BA_W-1:0]                bank_sel;

  sdram_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd), .fire(fire)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic sel, act_g, pre_g, ap_g;
      assign sel   = (ba == BA_W'(b));
      assign act_g = fire && (cmd == CMD_ACT) && sel && !bank_open[b];
      assign pre_g = fire && (cmd == CMD_PRE) && (ap_flag || sel) &&
                     bank_open[b] && !lock_v[b];
      assign ap_g  = fire && ((cmd == CMD_RD) || (cmd == CMD_WR)) && ap_flag &&
                     sel && bank_open[b] && !lock_v[b];
      sdram_bank_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(cke),
        .act(act_g), .pre(pre_g), .ap_start(ap_g), .ap_len(bl_q),
        .is_open(bank_open[b]), .locked(lock_v[b]),
        .t_act(t_act[b]), .t_pre(t_pre[b])
      );
    end
  endgenerate

  sdram_rule_check #(
    .NB(NUM_BANKS), .BA_W(BA_W), .CNT_W(CNT_W),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RRD(T_RRD), .T_RAS(T_RAS)
  ) u_rules (
    .cmd(cmd), .fire(fire), .ba(ba), .ap_flag(ap_flag),
    .mrs_win(mrs_cnt != '0), .open_v(bank_open), .lock_v(lock_v),
    .t_act(t_act), .t_pre(t_pre), .t_any_act(t_any_act),
    .code(code), .bank(bank_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrs_cnt   <= '0;
      bl_q      <= 4'd1;
      t_any_act <= SAT;
    end else if (cke) begin
      if (fire && cmd == CMD_MRS) begin
        mrs_cnt <= MRD_W'(T_MRD);
        bl_q    <= bl_decode(mr_bl_code);
      end else if (mrs_cnt != '0) begin
        mrs_cnt <= mrs_cnt - MRD_W'(1);
      end
      if (fire && cmd == CMD_ACT && !lock_v[ba] && !bank_open[ba])
        t_any_act <= CNT_W'(1);
      else if (t_any_act != SAT)
        t_any_act <= t_any_act + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 4'd0;
      err_bank  <= '0;
    end else begin
      err_valid <= (code != E_NONE);
      err_code  <= code;
      err_bank  <= bank_sel;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cke,
  input logic                         cs_n,
  input logic                         ras_n,
  input logic                         cas_n,
  input logic                         we_n,
  input logic [$clog2(NUM_BANKS)-1:0] ba,
  input logic                         err_valid,
  input logic [3:0]                   err_code,
  input logic [NUM_BANKS-1:0]         bank_open
);
  logic mrs_q;
  logic is_mrs, is_act, is_real;

  assign is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;
  assign is_act  = !cs_n && !ras_n && cas_n && we_n;
  assign is_real = !cs_n && !(ras_n && cas_n && we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mrs_q <= 1'b0;
    else if (cke) mrs_q <= is_mrs;
  end

  // R4
  strobe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid == (err_code != 4'd0));

  // R2
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(bank_open) && !err_valid));

  // R1
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !err_valid);

  // R5
  blackout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_q && cke && is_real) |=> (err_valid && err_code == 4'd1));

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && is_act && !bank_open[ba]) |=> bank_open[$past(ba)]);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .err_valid(err_valid),
  .err_code(err_code), .bank_open(bank_open)
);

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;
  localparam logic [2:0] P_MRS = 3'b000, P_REF = 3'b001, P_PRE = 3'b010,
                         P_ACT = 3'b011, P_WR = 3'b100, P_RD = 3'b101,
                         P_BST = 3'b110, P_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap_flag = 1'b0;
  logic [1:0] ba = '0;
  logic [2:0] mr_bl_code = '0;
  logic       err_valid;
  logic [3:0] err_code;
  logic [1:0] err_bank;
  logic [3:0] bank_open;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_cmd_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .ap_flag(ap_flag),
    .mr_bl_code(mr_bl_code), .err_valid(err_valid), .err_code(err_code),
    .err_bank(err_bank), .bank_open(bank_open)
  );

  task automatic drive(input logic k, input logic c, input logic [2:0] p,
                       input logic [1:0] b, input logic a, input logic [2:0] m);
    @(negedge clk);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; ap_flag = a; mr_bl_code = m;
    @(posedge clk);
    #2;
  endtask

  task automatic cmd(input logic [2:0] p, input logic [1:0] b, input logic a);
    drive(1'b1, 1'b0, p, b, a, 3'd0);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) cmd(P_NOP, 2'd0, 1'b0);
  endtask

  task automatic chk_err(input string req, input logic [3:0] code, input logic [1:0] bnk);
    logic ev;
    ev = (code != 4'd0);
    checks++;
    if (err_valid !== ev || err_code !== code || (ev && err_bank !== bnk)) begin
      fails++;
      $display("FAIL %s: valid/code/bank %0b/%0d/%0d expected %0b/%0d/%0d",
               req, err_valid, err_code, err_bank, ev, code, bnk);
    end
  endtask

  task automatic chk_open(input string req, input logic [3:0] exp);
    checks++;
    if (bank_open !== exp) begin
      fails++;
      $display("FAIL %s: bank_open %b expected %b", req, bank_open, exp);
    end
  endtask

  task automatic settle();
    nop(6);
    cmd(P_PRE, 2'd0, 1'b1);
    nop(4);
  endtask

  task automatic t_reset();
    chk_err("R4 reset", 4'd0, 2'd0);
    chk_open("R3 reset", 4'b0000);
  endtask

  task automatic t_legal();
    cmd(P_ACT, 2'd0, 1'b0); chk_err("R3 act", 0, 0); chk_open("R3 act", 4'b0001);
    nop(1);
    cmd(P_RD, 2'd0, 1'b0);  chk_err("R10 rd at tRCD", 0, 0);
    cmd(P_RD, 2'd0, 1'b0);  chk_err("R12 rd tCCD1", 0, 0);
    cmd(P_WR, 2'd0, 1'b0);  chk_err("R12 wr tCCD1", 0, 0);
    cmd(P_BST, 2'd0, 1'b0); chk_err("R12 burst stop", 0, 0);
    cmd(P_ACT, 2'd1, 1'b0); chk_open("R3 second bank", 4'b0011);
    nop(5);
    cmd(P_PRE, 2'd0, 1'b0); chk_err("R3 pre one", 0, 0); chk_open("R3 pre one", 4'b0010);
    cmd(P_PRE, 2'd2, 1'b1); chk_err("R3 pre all", 0, 0); chk_open("R3 pre all", 4'b0000);
    nop(3);
  endtask

  task automatic t_trcd();
    cmd(P_ACT, 2'd1, 1'b0);
    cmd(P_RD, 2'd1, 1'b0); chk_err("R10 tRCD", 4'd7, 2'd1);
    settle();
  endtask

  task automatic t_state_errs();
    cmd(P_WR, 2'd2, 1'b0); chk_err("R7 wr closed", 4'd5, 2'd2); chk_open("R7 no effect", 4'b0000);
    cmd(P_ACT, 2'd2, 1'b0);
    nop(1);
    cmd(P_ACT, 2'd2, 1'b0); chk_err("R7 act open", 4'd6, 2'd2); chk_open("R7 act open", 4'b0100);
    settle();
  endtask

  task automatic t_trrd();
    cmd(P_ACT, 2'd2, 1'b0);
    cmd(P_ACT, 2'd3, 1'b0); chk_err("R11 tRRD", 4'd9, 2'd3); chk_open("R11 takes effect", 4'b1100);
    settle();
  endtask

  task automatic t_tras_trp();
    cmd(P_ACT, 2'd0, 1'b0);
    nop(1);
    cmd(P_PRE, 2'd3, 1'b1); chk_err("R11 tRAS", 4'd10, 2'd0); chk_open("R11 closed", 4'b0000);
    cmd(P_ACT, 2'd0, 1'b0); chk_err("R10 tRP", 4'd8, 2'd0);
    settle();
  endtask

  task automatic t_mrs_ref_open();
    cmd(P_ACT, 2'd3, 1'b0);
    nop(2);
    drive(1'b1, 1'b0, P_MRS, 2'd0, 1'b0, 3'd0); chk_err("R6 mrs open", 4'd2, 2'd3);
    nop(2);
    cmd(P_REF, 2'd0, 1'b0); chk_err("R6 ref open", 4'd3, 2'd3);
    settle();
  endtask

  task automatic t_blackout();
    drive(1'b1, 1'b0, P_MRS, 2'd0, 1'b0, 3'd0); chk_err("R5 mrs closed", 0, 0);
    cmd(P_BST, 2'd0, 1'b0); chk_err("R5 bst in blackout", 4'd1, 2'd0);
    nop(1);
    cmd(P_ACT, 2'd1, 1'b0); chk_err("R5 after blackout", 0, 0);
    settle();
    drive(1'b1, 1'b0, P_MRS, 2'd0, 1'b0, 3'd0);
    nop(1);
    cmd(P_ACT, 2'd1, 1'b0); chk_err("R5 act second cycle", 4'd1, 2'd1);
    settle();
  endtask

  task automatic t_ignored();
    drive(1'b0, 1'b0, P_ACT, 2'd0, 1'b0, 3'd0);
    chk_err("R2 cke low", 0, 0); chk_open("R2 cke low", 4'b0000);
    drive(1'b1, 1'b1, P_ACT, 2'd0, 1'b0, 3'd0);
    chk_err("R1 deselect", 0, 0); chk_open("R1 deselect", 4'b0000);
  endtask

  task automatic t_autopre();
    drive(1'b1, 1'b0, P_MRS, 2'd0, 1'b0, 3'd2);
    nop(2);
    cmd(P_ACT, 2'd0, 1'b0);
    nop(1);
    cmd(P_RD, 2'd0, 1'b1); chk_err("R8 ap start", 0, 0);
    cmd(P_RD, 2'd0, 1'b0); chk_err("R8 lock", 4'd4, 2'd0);
    nop(2);                chk_open("R9 BL4 still open", 4'b0001);
    nop(1);                chk_open("R9 BL4 closed", 4'b0000);
    cmd(P_ACT, 2'd0, 1'b0); chk_err("R8 tRP from burst end", 4'd8, 2'd0);
    settle();
    drive(1'b1, 1'b0, P_MRS, 2'd0, 1'b0, 3'd0);
    nop(2);
    cmd(P_ACT, 2'd1, 1'b0);
    nop(1);
    cmd(P_WR, 2'd1, 1'b1);
    cmd(P_WR, 2'd1, 1'b0); chk_err("R8 lock BL1", 4'd4, 2'd1); chk_open("R9 BL1 closed", 4'b0000);
    cmd(P_RD, 2'd1, 1'b0); chk_err("R9 closed after BL1", 4'd5, 2'd1);
    settle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    t_reset();
    t_legal();
    t_trcd();
    t_state_errs();
    t_trrd();
    t_tras_trp();
    t_mrs_ref_open();
    t_blackout();
    t_ignored();
    t_autopre();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule